// File: doc/BRIEF.md
# Periodic SPI Result Transmitter

This block sends measurement results to one SPI slave on a fixed schedule. It runs on a 200 MHz system clock. It divides that clock down to a 3.125 MHz serial clock and opens a 16-bit transfer every 2000 system clocks, which is one transfer every 10 µs. The serial interface works in mode 0: the clock idles low, the slave samples on rising edges, and the data line changes on falling edges.

Each frame carries a kind flag and a 12-bit unsigned value. The flag is 0 for a distance and 1 for a speed. The upstream logic presents its latest distance and speed values, each with a one-cycle update strobe. A speed update marks a speed frame as pending, and that frame goes out in the next slot. A select input can also ask for a speed frame in a slot. In every other slot the block sends the latest distance. The frame is built and latched at the moment slave select falls, so new values that arrive during a transfer wait for the next slot.

Top module: `spi_result_tx`

## Requirements
- R1: While `rst` is high, and on the first sample after it is raised, `spi_cs_n_o` is 1, `spi_sclk_o` is 0 and `spi_mosi_o` is 0, even if a transfer was in progress.
- R2: Mode 0 behaviour. `spi_sclk_o` is low whenever `spi_cs_n_o` is high. During a transfer, `spi_mosi_o` changes only together with a falling edge of `spi_sclk_o`, and never while the clock is high.
- R3: One serial clock period is 64 system clocks, with 32 clocks high and 32 low. A frame has exactly 16 rising edges.
- R4: `spi_cs_n_o` first falls on the first clock edge after reset is released. It then falls again every 2000 system clocks.
- R5: The first rising edge of `spi_sclk_o` comes 32 clocks after `spi_cs_n_o` falls. `spi_cs_n_o` rises 32 clocks after the last falling edge, so it stays low for 1056 clocks.
- R6: The frame is sent MSB first. Bit 15 is the kind flag (0 = distance, 1 = speed), bits 14..3 are the 12-bit value, and bits 2..0 are 0.
- R7: The frame content is fixed at the clock edge where `spi_cs_n_o` falls. A strobe that arrives during a transfer does not change that frame; it takes effect in the next one.
- R8: A pulse on `spd_upd_i` captures `spd_val_i` and makes the next slot send a speed frame. The pending request is cleared once that frame starts, and later slots send distance frames. If both strobes arrive before the same slot, the speed frame goes out in that slot.
- R9: When `spd_sel_i` is high at the start of a slot, that slot sends a speed frame carrying the last captured speed value, even if no speed update is pending.
- R10: A pulse on `dist_upd_i` captures `dist_val_i`. Distance frames carry the last captured value, and that value is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_val_i | input | 12 | Latest distance value |
| dist_upd_i | input | 1 | One-cycle strobe that captures `dist_val_i` |
| spd_val_i | input | 12 | Latest speed value |
| spd_upd_i | input | 1 | One-cycle strobe that captures `spd_val_i` and requests a speed frame |
| spd_sel_i | input | 1 | Requests a speed frame in the slot that starts while it is high |
| spi_sclk_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the slave, MSB first |
| spi_cs_n_o | output | 1 | Active-low slave select |

## Verification
Every output is a register. After an edge where the slot counter reads zero, slave select is low on the next sample, and the serial clock rises 32 clocks later. The completed frame is therefore readable at the rise of slave select, 1056 clocks after it fell. The bench applies strobes only after a frame has completed and well before the next slot begins. It then compares the word that a rising-edge slave model captured in the following frame against the value the requirements predict, and it measures every edge interval in system-clock counts taken on the falling edge of `clk`. The test for R7 places its strobe 100 clocks into a transfer. It expects the old value in that frame and the new value in the one after.

// File: rtl/spi_res_pkg.sv
package spi_res_pkg;
  // Kind flag carried in the first bit of each frame.
  typedef enum logic {
    KIND_DIST  = 1'b0,
    KIND_SPEED = 1'b1
  } kind_e;
endpackage

// File: rtl/spi_res_slot.sv
// Free-running slot counter; start_o marks the first cycle of each slot.
module spi_res_slot #(
  parameter int PERIOD = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic start_o
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                            cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1))  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign start_o = (cnt_q == '0);

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(PERIOD)); // R4
endmodule

// File: rtl/spi_res_pick.sv
// Holds the latest values and the pending speed request, and forms the frame.
module spi_res_pick
  import spi_res_pkg::*;
#(
  parameter int VAL_W   = 12,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [VAL_W-1:0]   dist_i,
  input  logic               dist_stb_i,
  input  logic [VAL_W-1:0]   spd_i,
  input  logic               spd_stb_i,
  input  logic               spd_sel_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int PAD_W = FRAME_W - 1 - VAL_W;

  logic [VAL_W-1:0] dist_q, spd_q;
  logic             pend_q;
  kind_e            kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_q <= '0;
      spd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (dist_stb_i) dist_q <= dist_i;
      if (spd_stb_i)  spd_q  <= spd_i;
      if (spd_stb_i)                         pend_q <= 1'b1;
      else if (start_i && kind == KIND_SPEED) pend_q <= 1'b0;
    end
  end

  always_comb begin
    kind    = (pend_q || spd_sel_i) ? KIND_SPEED : KIND_DIST;
    frame_o = {kind, (kind == KIND_SPEED) ? spd_q : dist_q, {PAD_W{1'b0}}};
  end

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (start_i && pend_q && !spd_stb_i) |=> !pend_q); // R8
  AST_PEND_SETS: assert property (@(posedge clk) disable iff (rst)
    spd_stb_i |=> pend_q); // R8
endmodule

// File: rtl/spi_res_shift.sv
// Mode 0 serializer: slave select, divided serial clock, MSB-first data.
module spi_res_shift #(
  parameter int FRAME_W = 16,
  parameter int CLK_DIV = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_n_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME_W);

  logic               busy_q, tail_q;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sreg_q <= '0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
      cs_n_o <= 1'b1;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      tail_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      cs_n_o <= 1'b0;
      sclk_o <= 1'b0;
      mosi_o <= frame_i[FRAME_W-1];
      sreg_q <= {frame_i[FRAME_W-2:0], 1'b0};
    end else if (busy_q) begin
      div_q <= (div_q == DIV_W'(CLK_DIV - 1)) ? '0 : div_q + 1'b1;
      if (div_q == DIV_W'(HALF - 1)) begin
        if (tail_q) begin
          cs_n_o <= 1'b1;
          mosi_o <= 1'b0;
          busy_q <= 1'b0;
          tail_q <= 1'b0;
        end else begin
          sclk_o <= 1'b1;
        end
      end
      if (div_q == DIV_W'(CLK_DIV - 1)) begin
        sclk_o <= 1'b0;
        if (bit_q == BIT_W'(FRAME_W - 1)) begin
          tail_q <= 1'b1;
        end else begin
          bit_q  <= bit_q + 1'b1;
          mosi_o <= sreg_q[FRAME_W-1];
          sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o); // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q); // R4
  AST_SELECT_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> !sclk_o); // R5
endmodule

// File: rtl/spi_result_tx.sv
module spi_result_tx #(
  parameter int SYS_PER_SLOT = 2000,
  parameter int CLK_DIV      = 64,
  parameter int VAL_W        = 12,
  parameter int FRAME_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] dist_val_i,
  input  logic             dist_upd_i,
  input  logic [VAL_W-1:0] spd_val_i,
  input  logic             spd_upd_i,
  input  logic             spd_sel_i,
  output logic             spi_sclk_o,
  output logic             spi_mosi_o,
  output logic             spi_cs_n_o
);
  logic               slot_start;
  logic [FRAME_W-1:0] frame;

  spi_res_slot #(.PERIOD(SYS_PER_SLOT)) u_slot (
    .clk(clk), .rst(rst), .start_o(slot_start)
  );

  spi_res_pick #(.VAL_W(VAL_W), .FRAME_W(FRAME_W)) u_pick (
    .clk(clk), .rst(rst), .start_i(slot_start),
    .dist_i(dist_val_i), .dist_stb_i(dist_upd_i),
    .spd_i(spd_val_i), .spd_stb_i(spd_upd_i), .spd_sel_i(spd_sel_i),
    .frame_o(frame)
  );

  spi_res_shift #(.FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start_i(slot_start), .frame_i(frame),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .cs_n_o(spi_cs_n_o)
  );
endmodule

// File: tb/sim_spi_result_tx.sv
module sim_spi_result_tx;
  localparam int CLK_PERIOD = 5;
  localparam int SLOT = 2000;

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] dist_val = '0, spd_val = '0;
  logic dist_upd = 1'b0, spd_upd = 1'b0, spd_sel = 1'b0;
  logic sclk, mosi, cs_n;

  spi_result_tx u0 (
    .clk(clk), .rst(rst), .dist_val_i(dist_val), .dist_upd_i(dist_upd),
    .spd_val_i(spd_val), .spd_upd_i(spd_upd), .spd_sel_i(spd_sel),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_cs_n_o(cs_n)
  );

  always #(CLK_PERIOD/2.0) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input bit kind, input logic [11:0] v);
    return {kind, v, 3'b000};
  endfunction

  // Slave model and timing monitor
  int frames = 0, fall_cyc = 0, last_rise = 0, last_fall = 0, nbits = 0;
  int idle_bad = 0, mosi_bad = 0, per_bad = 0;
  bit have_fall = 0, first_rise = 0;
  logic [15:0] sh = '0, rx_word = '0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      have_fall = 0; p_cs = 1'b1; p_sclk = 1'b0; p_mosi = 1'b0;
    end else begin
      if (p_cs && !cs_n) begin
        if (have_fall) chk(cyc - fall_cyc == SLOT, "R4 slot spacing", cyc - fall_cyc, SLOT);
        fall_cyc = cyc; have_fall = 1; nbits = 0; sh = '0; first_rise = 1;
      end
      if (!p_cs && cs_n) begin
        chk(nbits == 16, "R3 rising edges per frame", nbits, 16);
        chk(cyc - last_fall == 32, "R5 select rise after last fall", cyc - last_fall, 32);
        chk(cyc - fall_cyc == 1056, "R5 select low time", cyc - fall_cyc, 1056);
        rx_word = sh; frames++;
      end
      if (!p_sclk && sclk) begin
        if (first_rise) begin
          chk(cyc - fall_cyc == 32, "R5 lead to first rise", cyc - fall_cyc, 32);
          first_rise = 0;
        end else if (cyc - last_rise != 64) per_bad++;
        last_rise = cyc; sh = {sh[14:0], mosi}; nbits++;
      end
      if (p_sclk && !sclk) begin
        if (cyc - last_rise != 32) per_bad++;
        last_fall = cyc;
      end
      if (sclk && cs_n) idle_bad++;
      if (mosi != p_mosi && !(p_sclk && !sclk) && (p_cs == cs_n)) mosi_bad++;
      p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end
  end

  task automatic wait_frame();
    int n = frames;
    while (frames == n) @(negedge clk);
  endtask

  typedef struct packed {
    logic dstb; logic [11:0] dval;
    logic sstb; logic [11:0] sval;
    logic sel; logic ekind; logic [11:0] eval;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 12'h123, 1'b0, 12'h000, 1'b0, 1'b0, 12'h123}, // R6 R10 distance
    '{1'b1, 12'hFFF, 1'b0, 12'h000, 1'b0, 1'b0, 12'hFFF}, // R6 all ones
    '{1'b0, 12'h000, 1'b1, 12'hABC, 1'b0, 1'b1, 12'hABC}, // R8 speed update
    '{1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 12'hFFF}, // R8 pending cleared
    '{1'b0, 12'h000, 1'b0, 12'h000, 1'b1, 1'b1, 12'hABC}, // R9 select forces speed
    '{1'b1, 12'h001, 1'b1, 12'h555, 1'b0, 1'b1, 12'h555}, // R8 both strobes
    '{1'b0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0, 12'h001}, // R10 held distance
    '{1'b0, 12'h000, 1'b1, 12'h000, 1'b0, 1'b1, 12'h000}  // R8 zero speed
  };

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 reset idle", {cs_n, sclk, mosi}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b0, "R4 first select fall after reset", cs_n, 0);
    wait_frame();
    chk(rx_word == 16'h0000, "R10 reset distance frame", rx_word, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      repeat (10) @(negedge clk);
      dist_val = TBL[i].dval; dist_upd = TBL[i].dstb;
      spd_val = TBL[i].sval; spd_upd = TBL[i].sstb;
      spd_sel = TBL[i].sel;
      @(negedge clk);
      dist_upd = 1'b0; spd_upd = 1'b0;
      wait_frame();
      spd_sel = 1'b0;
      chk(rx_word == word(TBL[i].ekind, TBL[i].eval), "R6 R8 R9 R10 table frame",
          rx_word, word(TBL[i].ekind, TBL[i].eval));
    end

    // R7: strobe during a transfer must not alter that frame
    while (cs_n) @(negedge clk);
    repeat (100) @(negedge clk);
    dist_val = 12'h0F0; dist_upd = 1'b1;
    @(negedge clk);
    dist_upd = 1'b0;
    wait_frame();
    chk(rx_word == word(1'b0, 12'h001), "R7 frame latched at select fall", rx_word, word(1'b0, 12'h001));
    wait_frame();
    chk(rx_word == word(1'b0, 12'h0F0), "R7 update in next frame", rx_word, word(1'b0, 12'h0F0));

    // R1: reset in the middle of a transfer
    while (cs_n) @(negedge clk);
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 mid-transfer reset", {cs_n, sclk, mosi}, 3'b100);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_frame();
    chk(rx_word == 16'h0000, "R10 values cleared by reset", rx_word, 16'h0000);
    wait_frame();

    chk(idle_bad == 0, "R2 clock low while deselected", idle_bad, 0);
    chk(mosi_bad == 0, "R2 data moves only on falling edge", mosi_bad, 0);
    chk(per_bad == 0, "R3 serial clock period and duty", per_bad, 0);
    report();
  end
endmodule